// File: doc/BRIEF.md
# DAC Interval Trigger Generator

This block produces the conversion-start pulse for a digital-to-analog converter. In its counting mode it keeps a 16-bit interval counter. A main trigger event, either a hardware edge or a software request that arrives already reduced to a one-cycle pulse, clears the counter and arms it. After that the counter advances once on every cycle where the shared prescaler count enable is high. Each time the count reaches the programmed interval, the block emits a one-clock pulse and starts the count again from zero. This repeats for as long as the main timebase keeps running. Every new main trigger event re-arms the counter from zero, so the DAC update pattern stays locked to the event that began the conversion sequence.

In its external mode the counter takes no part. Each rising edge on an external trigger line becomes exactly one output pulse. A single enable gates both modes. The prescaler and the DAC data path belong to neighbouring blocks.

Top module: `dit_dac_interval_trig`

## Requirements
- R1: While `cfg_enable` is 0, `dac_trig` is 0 in the cycle that follows.
- R2: In counting mode (`cfg_ext_mode` = 0), with `cfg_enable` = 1 and `run` = 1, a cycle with `trig_start` = 1 clears the counter and arms it. The count enable is not counted in that cycle. With interval N ≠ 0, the first pulse follows the N-th later cycle that has `count_en` = 1.
- R3: Once armed, `dac_trig` pulses for exactly one cycle after every N-th counted cycle, repeating indefinitely. The pulse appears in the cycle after the counted cycle that completes the interval.
- R4: The counter advances only in cycles where `count_en` = 1. A cycle with `count_en` = 0 in counting mode is followed by `dac_trig` = 0.
- R5: A `cfg_interval` value of 0 produces no pulses in counting mode.
- R6: In external mode (`cfg_ext_mode` = 1), with `cfg_enable` = 1, a cycle where `ext_trig` is 1 after being 0 in the previous cycle produces `dac_trig` = 1 in the next cycle. A level held high yields only that one pulse.
- R7: While `run` is 0 in counting mode, `dac_trig` stays 0 and the counter is disarmed. Pulses do not resume when `run` returns to 1 until a new `trig_start` arrives.
- R8: If `trig_start` arrives in the same cycle as the counted cycle that would complete the interval, the restart wins. No pulse follows, and the next pulse comes N counted cycles later.
- R9: In external mode, `trig_start` and `count_en` have no effect. `dac_trig` is 0 after every cycle without an `ext_trig` rising edge.
- R10: After synchronous reset `dac_trig` is 0 and the counter is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Enables the whole trigger function |
| cfg_ext_mode | input | 1 | 1 selects external pass-through; 0 selects interval counting |
| cfg_interval | input | CNT_W | Interval length in counted cycles |
| count_en | input | 1 | Prescaled count enable shared with the main timebase |
| trig_start | input | 1 | One-cycle pulse from the selected main trigger edge or the software trigger |
| run | input | 1 | High while the main timebase is running |
| ext_trig | input | 1 | External DAC trigger line (synchronous level) |
| dac_trig | output | 1 | One-clock DAC trigger pulse |

## Verification
Two events can fall in the same cycle: a main trigger restart and the counted cycle that would complete the interval. The bench provokes this by raising `trig_start` exactly on the cycle of the N-th count enable. It then judges that no pulse follows and that the next pulse comes only after N fresh count enables. Intervals 1 to 6 are swept against count-enable spacings of 1, 2 and 3 cycles. The expected pulse times are computed from the number of enables seen since the last restart, taken modulo the interval.

// File: rtl/dit_pkg.sv
package dit_pkg;

    localparam int DIT_CNT_W = 16;

    typedef enum logic {
        MODE_COUNT    = 1'b0,
        MODE_EXTERNAL = 1'b1
    } dit_mode_e;

    typedef struct packed {
        logic      enable;
        dit_mode_e mode;
        logic      run;
    } dit_ctrl_t;

    function automatic logic dit_rising(input logic cur, input logic prev);
        return cur & ~prev;
    endfunction

endpackage

// File: rtl/dit_rise_detect.sv
module dit_rise_detect (
    input  logic clk,
    input  logic sig,
    output logic rise
);
    import dit_pkg::*;

    logic sig_q;

    // Follows the line even during reset so the first post-reset edge is judged
    // against the real previous level.
    always_ff @(posedge clk) begin
        sig_q <= sig;
    end

    assign rise = dit_rising(sig, sig_q);

endmodule

// File: rtl/dit_interval_counter.sv
module dit_interval_counter #(
    parameter int CNT_W = dit_pkg::DIT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             disarm,
    input  logic             start,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    output logic             hit
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nx;
    logic             armed_q;
    logic             interval_nz;

    assign count_nx    = count_q + CNT_W'(1);
    assign interval_nz = |interval;
    assign hit         = armed_q && tick && !start && !disarm
                         && interval_nz && (count_nx == interval);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
            armed_q <= 1'b0;
        end else if (disarm) begin
            count_q <= '0;
            armed_q <= 1'b0;
        end else if (start) begin
            count_q <= '0;
            armed_q <= 1'b1;
        end else if (armed_q && tick) begin
            count_q <= hit ? '0 : count_nx;
        end
    end

endmodule

// File: rtl/dit_trig_select.sv
module dit_trig_select (
    input  logic               clk,
    input  logic               rst,
    input  dit_pkg::dit_ctrl_t ctrl,
    input  logic               cnt_hit,
    input  logic               ext_rise,
    output logic               trig
);
    import dit_pkg::*;

    logic trig_d;

    always_comb begin
        trig_d = 1'b0;
        if (ctrl.enable) begin
            unique case (ctrl.mode)
                MODE_EXTERNAL: trig_d = ext_rise;
                MODE_COUNT:    trig_d = cnt_hit;
                default:       trig_d = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) trig <= 1'b0;
        else     trig <= trig_d;
    end

endmodule

// File: rtl/dit_dac_interval_trig.sv
module dit_dac_interval_trig #(
    parameter int CNT_W = dit_pkg::DIT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_ext_mode,
    input  logic [CNT_W-1:0] cfg_interval,
    input  logic             count_en,
    input  logic             trig_start,
    input  logic             run,
    input  logic             ext_trig,
    output logic             dac_trig
);
    import dit_pkg::*;

    dit_ctrl_t ctrl;
    logic      disarm;
    logic      cnt_hit;
    logic      ext_rise;

    assign ctrl.enable = cfg_enable;
    assign ctrl.mode   = dit_mode_e'(cfg_ext_mode);
    assign ctrl.run    = run;

    assign disarm = !ctrl.enable || (ctrl.mode == MODE_EXTERNAL) || !ctrl.run;

    dit_rise_detect u_ext_edge (
        .clk  (clk),
        .sig  (ext_trig),
        .rise (ext_rise)
    );

    dit_interval_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .disarm   (disarm),
        .start    (trig_start),
        .tick     (count_en),
        .interval (cfg_interval),
        .hit      (cnt_hit)
    );

    dit_trig_select u_select (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .cnt_hit  (cnt_hit),
        .ext_rise (ext_rise),
        .trig     (dac_trig)
    );

endmodule

// File: rtl/dit_checker.sv
module dit_checker #(
    parameter int CNT_W = dit_pkg::DIT_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_enable,
    input logic             cfg_ext_mode,
    input logic [CNT_W-1:0] cfg_interval,
    input logic             count_en,
    input logic             trig_start,
    input logic             run,
    input logic             ext_trig,
    input logic             dac_trig
);

    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !dac_trig);

    p_tick_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ext_mode && !count_en) |=> !dac_trig);

    p_zero_interval_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ext_mode && cfg_interval == '0) |=> !dac_trig);

    p_ext_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_enable && cfg_ext_mode && ext_trig && !$past(ext_trig)) |=> dac_trig);

    p_halt_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ext_mode && !run) |=> !dac_trig);

    p_restart_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_ext_mode && trig_start) |=> !dac_trig);

    p_ext_no_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (cfg_ext_mode && !(ext_trig && !$past(ext_trig))) |=> !dac_trig);

    p_reset_quiet_r10: assert property (@(posedge clk)
        rst |=> !dac_trig);

endmodule

bind dit_dac_interval_trig dit_checker #(.CNT_W(CNT_W)) u_dit_checker (
    .clk          (clk),
    .rst          (rst),
    .cfg_enable   (cfg_enable),
    .cfg_ext_mode (cfg_ext_mode),
    .cfg_interval (cfg_interval),
    .count_en     (count_en),
    .trig_start   (trig_start),
    .run          (run),
    .ext_trig     (ext_trig),
    .dac_trig     (dac_trig)
);

// File: tb/tb_dit_dac_interval_trig.sv
module tb_dit_dac_interval_trig;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_enable = 1'b0;
    logic         cfg_ext_mode = 1'b0;
    logic [W-1:0] cfg_interval = '0;
    logic         count_en = 1'b0;
    logic         trig_start = 1'b0;
    logic         run = 1'b0;
    logic         ext_trig = 1'b0;
    logic         dac_trig;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Bench expectation state
    bit b_armed = 0;
    int b_tcount = 0;
    bit b_prev_x = 0;

    always #5 clk = ~clk;

    dit_dac_interval_trig #(.CNT_W(W)) dut (
        .clk          (clk),
        .rst          (rst),
        .cfg_enable   (cfg_enable),
        .cfg_ext_mode (cfg_ext_mode),
        .cfg_interval (cfg_interval),
        .count_en     (count_en),
        .trig_start   (trig_start),
        .run          (run),
        .ext_trig     (ext_trig),
        .dac_trig     (dac_trig)
    );

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: dac_trig=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one cycle, compute the expected output from the requirements, check it.
    task automatic cyc(input logic s, input logic t, input logic x, input string req);
        logic exp;
        logic rise;
        trig_start = s;
        count_en   = t;
        ext_trig   = x;
        rise       = x && !b_prev_x;
        b_prev_x   = x;
        if (!cfg_enable || cfg_ext_mode || !run) begin
            b_armed = 0;
            exp = cfg_enable && cfg_ext_mode && rise;
        end else if (s) begin
            b_armed  = 1;
            b_tcount = 0;
            exp = 1'b0;
        end else if (b_armed && t) begin
            b_tcount++;
            exp = (cfg_interval != 0) && ((b_tcount % int'(cfg_interval)) == 0);
        end else begin
            exp = 1'b0;
        end
        @(posedge clk);
        #1;
        check(dac_trig, exp, req);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(dac_trig, 1'b0, "R10");
        rst = 1'b0;
        cfg_enable = 1'b1;
        run = 1'b1;
        cyc(0, 1, 0, "R10");

        // R2 R3 R4: sweep interval against count-enable spacing
        for (int n = 1; n <= 6; n++) begin
            for (int p = 1; p <= 3; p++) begin
                cfg_interval = W'(n);
                cyc(1, 1, 0, "R2");
                for (int c = 0; c < 4 * n * p + 2; c++)
                    cyc(0, (c % p) == 0, 0, (c % p) == 0 ? "R3" : "R4");
            end
        end

        // R5: zero interval
        cfg_interval = '0;
        cyc(1, 1, 0, "R5");
        for (int c = 0; c < 40; c++) cyc(0, 1, 0, "R5");

        // R1: disabled
        cfg_interval = W'(3);
        cfg_enable = 1'b0;
        cyc(1, 1, 0, "R1");
        for (int c = 0; c < 12; c++) cyc(0, 1, c[0], "R1");
        cfg_enable = 1'b1;

        // R7: run drop disarms until new start
        cfg_interval = W'(4);
        cyc(1, 1, 0, "R7");
        for (int c = 0; c < 10; c++) cyc(0, 1, 0, "R7");
        run = 1'b0;
        for (int c = 0; c < 10; c++) cyc(0, 1, 0, "R7");
        run = 1'b1;
        for (int c = 0; c < 10; c++) cyc(0, 1, 0, "R7");
        cyc(1, 1, 0, "R7");
        for (int c = 0; c < 9; c++) cyc(0, 1, 0, "R7");

        // R8: restart collides with interval completion
        cfg_interval = W'(3);
        cyc(1, 1, 0, "R8");
        cyc(0, 1, 0, "R8");
        cyc(0, 1, 0, "R8");
        cyc(1, 1, 0, "R8");   // would be the 3rd count enable
        for (int c = 0; c < 7; c++) cyc(0, 1, 0, "R8");

        // R6 R9: external mode
        cfg_ext_mode = 1'b1;
        cyc(1, 1, 0, "R9");
        cyc(0, 1, 1, "R6");
        for (int c = 0; c < 5; c++) cyc(c[0], 1, 1, "R6");
        cyc(0, 1, 0, "R9");
        for (int c = 0; c < 16; c++) cyc(c[1], 1, c[0], "R6");
        for (int c = 0; c < 16; c++) cyc(1, 1, (c % 5) == 2, "R9");
        cfg_ext_mode = 1'b0;
        cyc(0, 1, 0, "R9");
        for (int c = 0; c < 6; c++) cyc(0, 1, 0, "R9");
        cyc(1, 1, 0, "R2");
        for (int c = 0; c < 7; c++) cyc(0, 1, 0, "R3");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule